// File: doc/BRIEF.md
# Memory-Mapped Parallel LCD Write Bridge

This block is a write-only slave on a simple valid/ready register bus. It turns CPU register writes into write cycles on a 16-bit parallel LCD controller bus of the 8080 kind. Each cycle has a chip select, a write strobe, a data/command select line and a 16-bit data bus. The block answers to a 16-byte address window. Three offsets in that window carry meaning: one pulses the panel reset, one sends a controller command word, and one sends pixel words.

A 32-bit pixel write becomes two back-to-back pixel cycles on the LCD bus. While an LCD cycle or a reset pulse is still running, the bridge holds its ready signal low. Software can therefore issue writes at any rate, and the bus simply waits. The read strobe is never used.

Top module: `lcd_wr_bridge`

## Requirements
- R1: A write whose address bits above bit 3 differ from those of `BASE_ADDR` is accepted and has no effect on any LCD output.
- R2: A write to offset 0x0 with data bit 0 = 1 drives `lcd_rst_n` low for exactly `RST_CYCLES` clock cycles, after which it rises by itself. With data bit 0 = 0, the write has no effect.
- R3: A write to offset 0x8 produces one LCD cycle with `lcd_dc` = 0 (command) and `lcd_data` = write data bits 15..0, whatever the size.
- R4: A write to offset 0xC with `bus_size` = 0 (16-bit) produces one LCD cycle with `lcd_dc` = 1 (data) and `lcd_data` = write data bits 15..0.
- R5: A write to offset 0xC with `bus_size` = 1 (32-bit) produces two data cycles in order: bits 15..0 first, then bits 31..16.
- R6: After a write that starts an LCD cycle is accepted, `bus_ready` stays low until every cycle that write causes has ended with `lcd_cs_n` high.
- R7: In each LCD cycle, `lcd_cs_n` falls one clock before `lcd_wr_n`. `lcd_wr_n` stays low for exactly `WR_LOW` clocks, and `lcd_cs_n` is still low for one clock after `lcd_wr_n` rises. `lcd_data` and `lcd_dc` hold steady throughout the whole time `lcd_cs_n` is low.
- R8: `lcd_rd_n` is high at all times.
- R9: While `lcd_rst_n` is low, `bus_ready` is low and no LCD cycle starts.
- R10: Writes to any offset in the window other than 0x0, 0x8 and 0xC have no effect.
- R11: After block reset, `bus_ready`, `lcd_cs_n`, `lcd_wr_n`, `lcd_rd_n` and `lcd_rst_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| bus_valid | input | 1 | Write request valid |
| bus_ready | output | 1 | Bridge can accept a write this cycle |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_size | input | 1 | 0 = 16-bit write, 1 = 32-bit write |
| bus_wdata | input | 2*LCD_W | Write data |
| lcd_rst_n | output | 1 | Panel controller reset, active low |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, held inactive |
| lcd_dc | output | 1 | 0 = command, 1 = pixel data |
| lcd_data | output | LCD_W | Parallel data bus |

## Verification
The bench builds the bridge with `WR_LOW` = 3 and `RST_CYCLES` = 10. A strobe longer than one clock exercises the strobe counter's reload and its decrement to zero. A short reset pulse keeps the stall-during-reset cases within a few clocks of the write that follows. A nonzero base address with a high bit set lets the bench flip single address bits above the window and confirm that nothing happens on the LCD side. Random mixes of 16- and 32-bit pixel writes, commands and unmapped offsets then run back to back, so that the two-cycle pixel split meets a stalled bus.

// File: rtl/lcd_br_pkg.sv
package lcd_br_pkg;

    localparam logic [3:0] OFF_RESET = 4'h0;
    localparam logic [3:0] OFF_CMD   = 4'h8;
    localparam logic [3:0] OFF_PIXEL = 4'hC;

    typedef enum logic [1:0] {
        CY_IDLE  = 2'd0,
        CY_SETUP = 2'd1,
        CY_STRB  = 2'd2,
        CY_HOLD  = 2'd3
    } cyc_state_e;

endpackage

// File: rtl/lcd_br_decode.sv
module lcd_br_decode #(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0010_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_reset,
    output logic              hit_cmd,
    output logic              hit_pixel
);
    import lcd_br_pkg::*;

    localparam int WIN_BITS = 4;

    logic            in_win;
    logic [WIN_BITS-1:0] offs;

    always_comb begin
        in_win    = (addr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
        offs      = addr[WIN_BITS-1:0];
        hit_reset = in_win && (offs == OFF_RESET);
        hit_cmd   = in_win && (offs == OFF_CMD);
        hit_pixel = in_win && (offs == OFF_PIXEL);
    end

endmodule

// File: rtl/lcd_br_rst_timer.sv
module lcd_br_rst_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic busy,
    output logic lcd_rst_n
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fire)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy      = (cnt_q != '0);
    assign lcd_rst_n = (cnt_q == '0);

    // R2: pulse releases itself after the last counted cycle
    p_rst_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(1)) |=> lcd_rst_n);
    // R9: no new reset request is taken while a pulse is running
    p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> lcd_rst_n);

endmodule

// File: rtl/lcd_br_cycle.sv
module lcd_br_cycle #(
    parameter int LCD_W  = 16,
    parameter int WR_LOW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LCD_W-1:0] st_data,
    input  logic             st_dc,
    output logic             busy,
    output logic             cs_n,
    output logic             wr_n,
    output logic             dc,
    output logic [LCD_W-1:0] data
);
    import lcd_br_pkg::*;

    localparam int CW = $clog2(WR_LOW + 1);
    localparam logic [CW-1:0] STRB_LOAD = CW'(WR_LOW - 1);

    typedef struct packed {
        cyc_state_e       st;
        logic [CW-1:0]    cnt;
        logic             cs_n;
        logic             wr_n;
        logic             dc;
        logic [LCD_W-1:0] data;
    } cyc_regs_t;

    cyc_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            CY_IDLE: begin
                if (start) begin
                    r_d.st   = CY_SETUP;
                    r_d.cs_n = 1'b0;
                    r_d.data = st_data;
                    r_d.dc   = st_dc;
                end
            end
            CY_SETUP: begin
                r_d.st   = CY_STRB;
                r_d.wr_n = 1'b0;
                r_d.cnt  = STRB_LOAD;
            end
            CY_STRB: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = CY_HOLD;
                    r_d.wr_n = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            CY_HOLD: begin
                r_d.st   = CY_IDLE;
                r_d.cs_n = 1'b1;
            end
            default: r_d.st = CY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= CY_IDLE;
            r_q.cnt  <= '0;
            r_q.cs_n <= 1'b1;
            r_q.wr_n <= 1'b1;
            r_q.dc   <= 1'b0;
            r_q.data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != CY_IDLE);
    assign cs_n = r_q.cs_n;
    assign wr_n = r_q.wr_n;
    assign dc   = r_q.dc;
    assign data = r_q.data;

    // R7: strobe only inside an active chip select
    p_wr_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.wr_n |-> !r_q.cs_n);
    // R7: after the strobe rises, select stays low and data is unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wr_n) |-> (!r_q.cs_n && $stable(r_q.data) && $stable(r_q.dc)));
    // R7: select leads the strobe by a cycle
    p_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.wr_n) |-> $past(!r_q.cs_n));

endmodule

// File: rtl/lcd_wr_bridge.sv
module lcd_wr_bridge #(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] BASE_ADDR  = 32'h0010_0000,
    parameter int          LCD_W      = 16,
    parameter int          WR_LOW     = 2,
    parameter int          RST_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    output logic               bus_ready,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_size,
    input  logic [2*LCD_W-1:0] bus_wdata,
    output logic               lcd_rst_n,
    output logic               lcd_cs_n,
    output logic               lcd_wr_n,
    output logic               lcd_rd_n,
    output logic               lcd_dc,
    output logic [LCD_W-1:0]   lcd_data
);
    typedef struct packed {
        logic             pend;
        logic [LCD_W-1:0] pend_data;
    } top_regs_t;

    top_regs_t r_d, r_q;

    logic             hit_reset, hit_cmd, hit_pixel;
    logic             accept, rst_fire, rst_busy, eng_busy;
    logic             eng_start, eng_dc;
    logic [LCD_W-1:0] eng_data;

    lcd_br_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr      (bus_addr),
        .hit_reset (hit_reset),
        .hit_cmd   (hit_cmd),
        .hit_pixel (hit_pixel)
    );

    lcd_br_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (rst_fire),
        .busy      (rst_busy),
        .lcd_rst_n (lcd_rst_n)
    );

    lcd_br_cycle #(.LCD_W(LCD_W), .WR_LOW(WR_LOW)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .st_data (eng_data),
        .st_dc   (eng_dc),
        .busy    (eng_busy),
        .cs_n    (lcd_cs_n),
        .wr_n    (lcd_wr_n),
        .dc      (lcd_dc),
        .data    (lcd_data)
    );

    assign bus_ready = !eng_busy && !r_q.pend && !rst_busy;
    assign accept    = bus_valid && bus_ready;
    assign rst_fire  = accept && hit_reset && bus_wdata[0];
    assign lcd_rd_n  = 1'b1;

    always_comb begin
        r_d       = r_q;
        eng_start = 1'b0;
        eng_data  = bus_wdata[LCD_W-1:0];
        eng_dc    = 1'b0;
        if (r_q.pend && !eng_busy) begin
            eng_start = 1'b1;
            eng_data  = r_q.pend_data;
            eng_dc    = 1'b1;
            r_d.pend  = 1'b0;
        end else if (accept && (hit_cmd || hit_pixel)) begin
            eng_start = 1'b1;
            eng_dc    = hit_pixel;
            if (hit_pixel && bus_size) begin
                r_d.pend      = 1'b1;
                r_d.pend_data = bus_wdata[2*LCD_W-1:LCD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pend      <= 1'b0;
            r_q.pend_data <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R6: an accepted LCD write blocks the next request
    p_accept_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (hit_cmd || hit_pixel)) |=> !bus_ready);
    // R9: no LCD cycle while the panel is held in reset
    p_rst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (lcd_cs_n && !bus_ready));
    // R5: the second half goes out as a pixel cycle
    p_second_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pend && !eng_busy) |=> (!lcd_cs_n && lcd_dc));

endmodule

// File: tb/lcd_wr_bridge_tb_top.sv
`timescale 1ns/1ps
module lcd_wr_bridge_tb_top;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h8004_2A50;
    localparam int          WRL  = 3;
    localparam int          RSTC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic [31:0] bus_addr = '0;
    logic        bus_size = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        lcd_rst_n, lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_dc;
    logic [15:0] lcd_data;

    always #2.5 clk = ~clk;

    lcd_wr_bridge #(.ADDR_W(AW), .BASE_ADDR(BASE), .LCD_W(16),
                    .WR_LOW(WRL), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .lcd_rst_n(lcd_rst_n), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
        .lcd_rd_n(lcd_rd_n), .lcd_dc(lcd_dc), .lcd_data(lcd_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [15:0] exp_d  [0:1023];
    logic        exp_dc [0:1023];
    int n_exp = 0;
    int n_obs = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    // expected LCD traffic, derived from R1..R5 and R10
    function automatic void push_expect(input logic [31:0] a, input logic sz, input logic [31:0] d);
        if (a[31:4] != BASE[31:4]) return;
        if (a[3:0] == 4'h8) begin
            exp_d[n_exp] = d[15:0]; exp_dc[n_exp] = 1'b0; n_exp++;
        end else if (a[3:0] == 4'hC) begin
            exp_d[n_exp] = d[15:0]; exp_dc[n_exp] = 1'b1; n_exp++;
            if (sz) begin
                exp_d[n_exp] = d[31:16]; exp_dc[n_exp] = 1'b1; n_exp++;
            end
        end
    endfunction

    task automatic bus_wr(input logic [31:0] a, input logic sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        while (!bus_ready) @(negedge clk);
        @(posedge clk);
        push_expect(a, sz, d);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // LCD-side monitor, sampled on the falling clock edge
    logic        prev_cs = 1'b1, prev_wr = 1'b1, prev_rst = 1'b1;
    logic [15:0] cap_d;
    logic        cap_dc;
    int          wr_low_cnt = 0, rst_low_cnt = 0;
    bit          setup_bad = 0, stable_bad = 0, r6_viol = 0, r9_viol = 0, rd_bad = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!lcd_rd_n) rd_bad = 1;
            if (!lcd_cs_n && bus_ready) r6_viol = 1;
            if (!lcd_rst_n && (bus_ready || !lcd_cs_n)) r9_viol = 1;
            if (prev_cs && !lcd_cs_n) begin
                cap_d = lcd_data; cap_dc = lcd_dc;
                if (!lcd_wr_n) setup_bad = 1;
            end
            if (!lcd_cs_n && (lcd_data != cap_d || lcd_dc != cap_dc)) stable_bad = 1;
            if (!lcd_wr_n) wr_low_cnt++;
            if (!prev_wr && lcd_wr_n) begin
                chk(wr_low_cnt == WRL, "R7 strobe width", wr_low_cnt, WRL);
                chk(!lcd_cs_n, "R7 select held after strobe", lcd_cs_n, 0);
                if (n_obs < n_exp) begin
                    chk(cap_d == exp_d[n_obs], exp_dc[n_obs] ? "R4/R5 pixel word" : "R3 command word",
                        cap_d, exp_d[n_obs]);
                    chk(cap_dc == exp_dc[n_obs], "R3/R4 dc level", cap_dc, exp_dc[n_obs]);
                end else begin
                    chk(0, "R1/R10 unexpected LCD cycle", cap_d, 0);
                end
                n_obs++;
                wr_low_cnt = 0;
            end
            if (!prev_cs && lcd_cs_n) begin
                chk(!setup_bad, "R7 select before strobe", setup_bad, 0);
                chk(!stable_bad, "R7 data stable", stable_bad, 0);
                chk(!r6_viol, "R6 ready low during cycle", r6_viol, 0);
                setup_bad = 0; stable_bad = 0; r6_viol = 0;
            end
            if (!lcd_rst_n) rst_low_cnt++;
            if (!prev_rst && lcd_rst_n) begin
                chk(rst_low_cnt == RSTC, "R2 reset pulse width", rst_low_cnt, RSTC);
                chk(!r9_viol, "R9 stall during reset", r9_viol, 0);
                rst_low_cnt = 0; r9_viol = 0;
            end
            prev_cs = lcd_cs_n; prev_wr = lcd_wr_n; prev_rst = lcd_rst_n;
        end
    end

    task automatic check_no_effect(input string req);
        int snap;
        snap = n_obs;
        repeat (12) @(negedge clk);
        chk(n_obs == snap, req, n_obs, snap);
        chk(lcd_cs_n && lcd_rst_n, req, {lcd_cs_n, lcd_rst_n}, 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(bus_ready == 1'b1, "R11 ready", bus_ready, 1);
        chk(lcd_cs_n == 1'b1, "R11 cs_n", lcd_cs_n, 1);
        chk(lcd_wr_n == 1'b1, "R11 wr_n", lcd_wr_n, 1);
        chk(lcd_rd_n == 1'b1, "R11 rd_n", lcd_rd_n, 1);
        chk(lcd_rst_n == 1'b1, "R11 lcd_rst_n", lcd_rst_n, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_ready && lcd_cs_n && lcd_rst_n, "R11 after release", bus_ready, 1);

        // R3, R4, R5 directed
        bus_wr(BASE | 32'h8, 1'b0, 32'h0000_A55A);
        bus_wr(BASE | 32'hC, 1'b0, 32'h0000_F00D);
        bus_wr(BASE | 32'hC, 1'b1, 32'h1234_BEEF);
        bus_wr(BASE | 32'h8, 1'b1, 32'hFFFF_0042);   // R3 upper half unused
        // R1 outside window, R10 unmapped offsets
        bus_wr(BASE ^ 32'h0000_0010 | 32'h8, 1'b0, 32'h1111);
        check_no_effect("R1 outside window");
        bus_wr(BASE ^ 32'h8000_0000 | 32'hC, 1'b1, 32'h2222_3333);
        check_no_effect("R1 high address bit");
        bus_wr(BASE | 32'h4, 1'b1, 32'hFFFF_FFFF);
        check_no_effect("R10 offset 4");
        bus_wr(BASE | 32'hE, 1'b0, 32'h0000_7777);
        check_no_effect("R10 offset E");
        // R2 bit0 clear
        bus_wr(BASE | 32'h0, 1'b1, 32'hFFFF_FFFE);
        check_no_effect("R2 bit0 clear");
        // R2/R9 reset pulse followed at once by a pixel write
        bus_wr(BASE | 32'h0, 1'b0, 32'h0000_0001);
        @(negedge clk);
        chk(!lcd_rst_n && !bus_ready, "R9 reset active stalls", {lcd_rst_n, bus_ready}, 0);
        bus_wr(BASE | 32'hC, 1'b1, 32'hCAFE_0001);

        // random mix
        for (int i = 0; i < 120; i++) begin
            int k;
            logic [31:0] a, d;
            logic sz;
            k  = $urandom_range(0, 9);
            d  = $urandom;
            sz = 1'($urandom_range(0, 1));
            case (k)
                0, 1, 2: a = BASE | 32'hC;
                3, 4:    a = BASE | 32'h8;
                5:       a = (BASE ^ (32'h1 << $urandom_range(4, 31))) | 32'($urandom_range(0, 15));
                6: begin
                    logic [3:0] o;
                    o = 4'($urandom_range(0, 15));
                    if (o == 4'h0 || o == 4'h8 || o == 4'hC) o = 4'h6;
                    a = BASE | {28'h0, o};
                end
                7:       begin a = BASE; d[0] = ($urandom_range(0, 3) == 0); end
                default: a = BASE | 32'hC;
            endcase
            bus_wr(a, sz, d);
        end
        repeat (40) @(negedge clk);
        chk(n_obs == n_exp, "R1/R10 total LCD cycles", n_obs, n_exp);
        chk(!rd_bad, "R8 read strobe idle", rd_bad, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule